// File: doc/BRIEF.md
# Tagged Receive Byte Queue with Fill and Packet Events

This block buffers bytes coming out of a serial-link packet receiver until a processor collects them. Every stored entry holds one data byte together with a tag bit that marks the final byte of a packet. The entry at the head of the queue is always presented on the read port, so a read strobe consumes the byte that is already visible.

Alongside the data path the block produces three single-cycle event pulses that an interrupt controller can mask and collect. The first fires when the fill level climbs past a threshold. The second fires when a write arrives while the queue is full. The third fires when the byte now at the head is the last byte of its packet, or when the processor strobes a read while the queue is empty. Each event is registered and appears in the cycle after the condition that causes it.

Depth (32 by default), data width and threshold (16 by default) are parameters. Reset is synchronous and active high.

Top module: `rxq_pkt_fifo`

## Requirements
- R1: While `rst` is high at a rising edge, the queue empties: after that edge `fill_count` is 0, `empty` is 1, `full` is 0 and all three event outputs are 0.
- R2: Entries leave in the order they were written, each with its own tag. `rd_data` and `rd_eop` always show the head entry while `empty` is 0, and a strobe of `rd_en` consumes it.
- R3: A `wr_en` while `fill_count` equals DEPTH and `rd_en` is low is an overflow. The byte is dropped, the stored contents stay as they were, and `evt_ovfl` is 1 for exactly the next cycle.
- R4: When the queue is full and `wr_en` and `rd_en` are both high in the same cycle, the head is consumed and the new byte is stored. `fill_count` stays at DEPTH and `evt_ovfl` stays 0.
- R5: `evt_thresh` is 1 for one cycle right after an edge at which the fill level moves from THRESH to THRESH+1. It does not fire again while the level stays above THRESH; it fires again only on a new crossing.
- R6: `evt_eop` is 1 for one cycle right after the first edge at which a tagged entry stands at the head of the queue. The pulse comes once per tagged entry, whether or not that entry is consumed at the same edge.
- R7: A `rd_en` while `empty` is 1 changes no stored state and makes `evt_eop` 1 in the next cycle. A write in the same cycle is still accepted.
- R8: `fill_count` equals the number of stored entries. `empty` is 1 exactly when that number is 0, and `full` is 1 exactly when it equals DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe from the packet receiver |
| wr_data | input | DATA_W | Byte to store |
| wr_eop | input | 1 | 1 marks the byte as the final byte of its packet |
| rd_en | input | 1 | Read strobe from the processor side |
| rd_data | output | DATA_W | Byte at the head of the queue |
| rd_eop | output | 1 | Tag of the head entry |
| fill_count | output | $clog2(DEPTH+1) | Number of stored entries |
| empty | output | 1 | No entries stored |
| full | output | 1 | DEPTH entries stored |
| evt_thresh | output | 1 | One-cycle pulse on the crossing above THRESH |
| evt_ovfl | output | 1 | One-cycle pulse after a dropped write |
| evt_eop | output | 1 | One-cycle pulse for a tagged head entry or an empty read |

## Verification
The properties assume that `rd_en` and `wr_en` are free of X after reset. They also assume that the head-output properties are judged only while `empty` is low, since `rd_data` then comes from a valid slot. The bench drives every strobe from a task at the falling edge and holds `rst` high with both strobes low from time zero. Empty reads, full-queue writes and simultaneous read-and-write at full are therefore the only boundary conditions it exercises, and all of them are legal inputs.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

   // Registered event bundle produced by the event stage.
   typedef struct packed {
      logic thresh;
      logic ovfl;
      logic eop;
   } rxq_evt_t;

   // True when the value is a power of two (and non-zero).
   function automatic bit rxq_is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 32,
   parameter int unsigned AW     = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              weop,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata,
   output logic              reop
);

   localparam int unsigned EW = DATA_W + 1;

   logic [EW-1:0] slot [DEPTH];

   // One register per slot; contents need no reset since occupancy
   // is tracked by the control stage.
   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (we && (waddr == AW'(i))) begin
            slot[i] <= {weop, wdata};
         end
      end
   end

   // Show-ahead read: the head entry is always presented.
   logic [EW-1:0] head;
   always_comb begin
      head  = slot[raddr];
      rdata = head[DATA_W-1:0];
      reop  = head[EW-1];
   end

endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
   parameter int unsigned DEPTH = 32,
   parameter int unsigned AW    = $clog2(DEPTH),
   parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          wr_en,
   input  logic          rd_en,
   output logic          push,
   output logic          pop,
   output logic          empty_rd,
   output logic          ovf_try,
   output logic [AW-1:0] wr_ptr,
   output logic [AW-1:0] rd_ptr,
   output logic [CW-1:0] count,
   output logic          empty,
   output logic          full
);

   import rxq_pkg::*;

   localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);
   localparam logic [AW-1:0] PTR_TOP = AW'(DEPTH - 1);

   logic [AW-1:0] wr_ptr_nx;
   logic [AW-1:0] rd_ptr_nx;

   // Pointer advance: natural wrap for power-of-two depths,
   // explicit wrap otherwise.
   if (rxq_is_pow2(DEPTH)) begin : g_wrap_pow2
      assign wr_ptr_nx = wr_ptr + 1'b1;
      assign rd_ptr_nx = rd_ptr + 1'b1;
   end else begin : g_wrap_cmp
      assign wr_ptr_nx = (wr_ptr == PTR_TOP) ? '0 : wr_ptr + 1'b1;
      assign rd_ptr_nx = (rd_ptr == PTR_TOP) ? '0 : rd_ptr + 1'b1;
   end

   always_comb begin
      empty    = (count == '0);
      full     = (count == CNT_MAX);
      pop      = rd_en && !empty;
      // A full queue still accepts a write when a read frees a slot.
      push     = wr_en && (!full || pop);
      empty_rd = rd_en && empty;
      ovf_try  = wr_en && full && !rd_en;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr_nx;
         if (pop)  rd_ptr <= rd_ptr_nx;
         unique case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

endmodule

// File: rtl/rxq_events.sv
module rxq_events #(
   parameter int unsigned DEPTH  = 32,
   parameter int unsigned THRESH = 16,
   parameter int unsigned CW     = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              push,
   input  logic              pop,
   input  logic              empty,
   input  logic              empty_rd,
   input  logic              ovf_try,
   input  logic              head_eop,
   input  logic [CW-1:0]     count,
   output rxq_pkg::rxq_evt_t evt
);

   localparam logic [CW-1:0] CNT_THR = CW'(THRESH);

   logic head_flagged;
   logic head_tag_live;
   logic cross_up;

   always_comb begin
      head_tag_live = !empty && head_eop;
      // Level moves THRESH -> THRESH+1 only on a net push.
      cross_up      = push && !pop && (count == CNT_THR);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         evt          <= '0;
         head_flagged <= 1'b0;
      end else begin
         evt.thresh <= cross_up;
         evt.ovfl   <= ovf_try;
         evt.eop    <= empty_rd || (head_tag_live && !head_flagged);
         // A pop brings a new entry to the head, which is unflagged.
         if (pop) head_flagged <= 1'b0;
         else     head_flagged <= head_flagged || head_tag_live;
      end
   end

endmodule

// File: rtl/rxq_pkt_fifo.sv
module rxq_pkt_fifo #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 32,
   parameter int unsigned THRESH = 16,
   localparam int unsigned AW    = $clog2(DEPTH),
   localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_eop,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_eop,
   output logic [CW-1:0]     fill_count,
   output logic              empty,
   output logic              full,
   output logic              evt_thresh,
   output logic              evt_ovfl,
   output logic              evt_eop
);

   // Elaboration-time parameter checks.
   if (DATA_W < 1) begin : g_bad_width
      $error("rxq_pkt_fifo: DATA_W must be at least 1");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("rxq_pkt_fifo: DEPTH must be at least 2");
   end
   if (THRESH >= DEPTH) begin : g_bad_thresh
      $error("rxq_pkt_fifo: THRESH must be below DEPTH");
   end

   logic          push, pop, empty_rd, ovf_try;
   logic [AW-1:0] wr_ptr, rd_ptr;
   rxq_pkg::rxq_evt_t evt;

   rxq_ctrl #(
      .DEPTH (DEPTH),
      .AW    (AW),
      .CW    (CW)
   ) u_ctrl (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (wr_en),
      .rd_en    (rd_en),
      .push     (push),
      .pop      (pop),
      .empty_rd (empty_rd),
      .ovf_try  (ovf_try),
      .wr_ptr   (wr_ptr),
      .rd_ptr   (rd_ptr),
      .count    (fill_count),
      .empty    (empty),
      .full     (full)
   );

   rxq_store #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH),
      .AW     (AW)
   ) u_store (
      .clk   (clk),
      .we    (push),
      .waddr (wr_ptr),
      .wdata (wr_data),
      .weop  (wr_eop),
      .raddr (rd_ptr),
      .rdata (rd_data),
      .reop  (rd_eop)
   );

   rxq_events #(
      .DEPTH  (DEPTH),
      .THRESH (THRESH),
      .CW     (CW)
   ) u_events (
      .clk      (clk),
      .rst      (rst),
      .push     (push),
      .pop      (pop),
      .empty    (empty),
      .empty_rd (empty_rd),
      .ovf_try  (ovf_try),
      .head_eop (rd_eop),
      .count    (fill_count),
      .evt      (evt)
   );

   assign evt_thresh = evt.thresh;
   assign evt_ovfl   = evt.ovfl;
   assign evt_eop    = evt.eop;

endmodule

// File: rtl/rxq_pkt_fifo_chk.sv
module rxq_pkt_fifo_chk #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 32,
   parameter int unsigned THRESH = 16,
   parameter int unsigned CW     = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst,
   input logic              wr_en,
   input logic              rd_en,
   input logic [DATA_W-1:0] rd_data,
   input logic              rd_eop,
   input logic [CW-1:0]     fill_count,
   input logic              empty,
   input logic              full,
   input logic              evt_thresh,
   input logic              evt_ovfl,
   input logic              evt_eop
);

   assert_reset_R1: assert property (@(posedge clk)
      rst |=> (fill_count == '0 && empty && !full && !evt_thresh && !evt_ovfl && !evt_eop));

   assert_head_hold_R2: assert property (@(posedge clk) disable iff (rst)
      (!empty && !rd_en) |=> ($stable(rd_data) && $stable(rd_eop)));

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
      evt_ovfl |-> $past(full && wr_en && !rd_en));

   assert_ovfl_pulse_R3: assert property (@(posedge clk) disable iff (rst)
      (full && wr_en && !rd_en) |=> (full && evt_ovfl));

   assert_full_rdwr_R4: assert property (@(posedge clk) disable iff (rst)
      (full && wr_en && rd_en) |=> (full && !evt_ovfl));

   assert_thresh_R5: assert property (@(posedge clk) disable iff (rst)
      evt_thresh |-> (fill_count == CW'(THRESH + 1) && $past(fill_count) == CW'(THRESH)));

   assert_eop_cause_R6: assert property (@(posedge clk) disable iff (rst)
      evt_eop |-> ($past(rd_en && empty) || $past(!empty && rd_eop)));

   assert_empty_read_R7: assert property (@(posedge clk) disable iff (rst)
      (empty && rd_en) |=> evt_eop);

   assert_count_up_R8: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !rd_en && !full) |=> (fill_count == $past(fill_count) + 1'b1));

   assert_flags_R8: assert property (@(posedge clk) disable iff (rst)
      !(empty && full));

endmodule

bind rxq_pkt_fifo rxq_pkt_fifo_chk #(
   .DATA_W (DATA_W),
   .DEPTH  (DEPTH),
   .THRESH (THRESH),
   .CW     (CW)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .wr_en      (wr_en),
   .rd_en      (rd_en),
   .rd_data    (rd_data),
   .rd_eop     (rd_eop),
   .fill_count (fill_count),
   .empty      (empty),
   .full       (full),
   .evt_thresh (evt_thresh),
   .evt_ovfl   (evt_ovfl),
   .evt_eop    (evt_eop)
);

// File: tb/rxq_pkt_fifo_bench.sv
module rxq_pkt_fifo_bench;

   localparam int DW = 8;
   localparam int DP = 32;
   localparam int TH = 16;
   localparam int CWB = $clog2(DP + 1);

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          wr_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic          wr_eop = 1'b0;
   logic          rd_en = 1'b0;
   logic [DW-1:0] rd_data;
   logic          rd_eop;
   logic [CWB-1:0] fill_count;
   logic          empty, full, evt_thresh, evt_ovfl, evt_eop;

   always #5 clk = ~clk;

   rxq_pkt_fifo #(.DATA_W(DW), .DEPTH(DP), .THRESH(TH)) u_rxq_pkt_fifo (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_eop(wr_eop),
      .rd_en(rd_en), .rd_data(rd_data), .rd_eop(rd_eop), .fill_count(fill_count),
      .empty(empty), .full(full), .evt_thresh(evt_thresh), .evt_ovfl(evt_ovfl),
      .evt_eop(evt_eop)
   );

   typedef struct {
      int data;
      bit eop;
      int id;
   } item_t;

   item_t sb[$];
   int    next_id = 0;
   int    flagged_id = -1;
   bit    exp_thr = 0, exp_ovf = 0, exp_eop = 0;
   int    n_checks = 0, n_fail = 0;
   bit    done = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   endtask

   // Compare the port state with the model (called at the falling edge).
   task automatic check_state();
      int sz = sb.size();
      chk(int'(fill_count) == sz, "R8 fill_count", int'(fill_count), sz);
      chk(empty == (sz == 0), "R8 empty", int'(empty), int'(sz == 0));
      chk(full == (sz == DP), "R8 full", int'(full), int'(sz == DP));
      chk(evt_thresh == exp_thr, "R5 evt_thresh", int'(evt_thresh), int'(exp_thr));
      chk(evt_ovfl == exp_ovf, "R3 evt_ovfl", int'(evt_ovfl), int'(exp_ovf));
      chk(evt_eop == exp_eop, "R6/R7 evt_eop", int'(evt_eop), int'(exp_eop));
   endtask

   // Driver: one clock cycle of stimulus plus the scoreboard update.
   task automatic cyc(input bit w, input int d, input bit e, input bit r);
      int  sz = sb.size();
      bit  rd_ok, wr_ok;
      item_t it;
      check_state();
      wr_en = w; wr_data = DW'(d); wr_eop = e; rd_en = r;
      rd_ok = r && (sz > 0);
      wr_ok = w && ((sz < DP) || rd_ok);
      if (rd_ok) begin
         chk(int'(rd_data) == sb[0].data, "R2 rd_data", int'(rd_data), sb[0].data);
         chk(rd_eop == sb[0].eop, "R2 rd_eop", int'(rd_eop), int'(sb[0].eop));
      end
      exp_ovf = w && (sz == DP) && !r;
      exp_thr = wr_ok && !rd_ok && (sz == TH);
      exp_eop = r && (sz == 0);
      if (sz > 0 && sb[0].eop && sb[0].id != flagged_id) begin
         exp_eop = 1;
         flagged_id = sb[0].id;
      end
      if (rd_ok) void'(sb.pop_front());
      if (wr_ok) begin
         it.data = d; it.eop = e; it.id = next_id; next_id++;
         sb.push_back(it);
      end
      @(posedge clk);
      @(negedge clk);
      wr_en = 0; rd_en = 0;
   endtask

   task automatic do_reset();
      rst = 1; wr_en = 0; rd_en = 0;
      @(posedge clk);
      @(negedge clk);
      sb.delete();
      exp_thr = 0; exp_ovf = 0; exp_eop = 0;
      chk(fill_count == '0, "R1 count after reset", int'(fill_count), 0);
      chk(empty && !full, "R1 flags after reset", int'({empty, full}), 2);
      chk(!evt_thresh && !evt_ovfl && !evt_eop, "R1 events after reset",
          int'({evt_thresh, evt_ovfl, evt_eop}), 0);
      rst = 0;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin : stim
      @(negedge clk);
      do_reset();

      // R2/R6: two packets, no reads, then drain with gaps.
      cyc(1, 8'h11, 0, 0);
      cyc(1, 8'h22, 0, 0);
      cyc(1, 8'h33, 1, 0);
      cyc(1, 8'h44, 1, 0);
      cyc(0, 0, 0, 0);
      for (int i = 0; i < 4; i++) begin
         cyc(0, 0, 0, 1);
         cyc(0, 0, 0, 0);
      end

      // R6: single tagged byte read immediately when it reaches the head.
      cyc(1, 8'h5A, 1, 0);
      cyc(0, 0, 0, 1);
      cyc(0, 0, 0, 0);

      // R7: empty reads, alone and with a simultaneous write.
      cyc(0, 0, 0, 1);
      cyc(0, 0, 0, 0);
      cyc(1, 8'h66, 0, 1);
      chk(int'(fill_count) == 1, "R7 write kept on empty read", int'(fill_count), 1);
      cyc(0, 0, 0, 1);
      cyc(0, 0, 0, 0);

      // R5/R8: fill to full, crossing threshold once.
      for (int i = 0; i < DP; i++) cyc(1, 8'h80 + i, (i % 5) == 4, 0);
      cyc(0, 0, 0, 0);

      // R3: overflow attempts are dropped.
      cyc(1, 8'hEE, 1, 0);
      cyc(1, 8'hEF, 0, 0);
      cyc(0, 0, 0, 0);

      // R4: simultaneous read and write while full.
      for (int i = 0; i < 3; i++) begin
         cyc(1, 8'hC0 + i, i == 1, 1);
         chk(full && !evt_ovfl, "R4 full rd+wr accepted", int'({full, evt_ovfl}), 2);
      end

      // R2/R3: drain everything, order and dropped bytes checked by scoreboard.
      for (int i = 0; i < DP; i++) cyc(0, 0, 0, 1);
      cyc(0, 0, 0, 0);

      // R5: hover around the threshold.
      for (int i = 0; i < TH; i++) cyc(1, i, 0, 0);
      cyc(1, 8'hA1, 0, 0);
      cyc(0, 0, 0, 1);
      cyc(1, 8'hA2, 1, 0);
      cyc(0, 0, 0, 0);
      for (int i = 0; i < 3; i++) cyc(1, 8'hB0 + i, 0, 0);
      cyc(1, 8'hB8, 0, 1);
      cyc(0, 0, 0, 0);

      // R1: reset with contents present.
      do_reset();
      cyc(0, 0, 0, 0);
      cyc(0, 0, 0, 1);
      cyc(0, 0, 0, 0);
      check_state();

      finish_run();
   end

endmodule